// File: doc/BRIEF.md
# Deskew Delay-Line Step Controller

This block is the digital control loop behind a variable clock delay line that aligns a regional clock with a reference clock. Each reference cycle it takes one sample from a phase comparator that has already been synchronised. The comparator reports whether the regional clock, as fed back, arrives early or late against the reference. The block keeps the delay setting as a thermometer code. Each bit enables one tap of the delay line, and the code only ever changes by shifting in at one of its ends.

Samples are counted over a fixed window of reference cycles. At the end of the window a strict majority of the samples can move the code by one position. If no majority forms, the code holds. A lock flag reports when the loop is dithering around alignment, and a sticky flag reports that a step was blocked at either end of the range. A manual mode stops the automatic loop. In that mode an external test controller can load a whole code or nudge it one step at a time. A separate enable decides whether the regional clock is allowed through, and has no effect on the delay setting.

Top module: `dll_deskew_ctrl`

## Requirements
- R1: After reset, `code_o` holds ones in bits 0 to STEPS/2-1 and zeros above them (20'h003FF at the defaults), and `lock_o`, `limit_o` and `clk_gate_o` are all 0.
- R2: `code_o` is always a thermometer code: its ones fill a contiguous run that starts at bit 0. Less delay shifts a 1 in at bit 0, so the count of ones goes up by one. More delay shifts a 0 in at bit STEPS-1, so the count of ones goes down by one.
- R3: In automatic mode the code can change only at the clock edge that ends a WINDOW-cycle window (16 cycles by default). Windows are counted from the first edge after reset, and restart from the first edge after manual mode ends.
- R4: Within a window, a sample counts as late when `late_i`=1 and `early_i`=0, and as early in the opposite case. More than WINDOW/2 late samples give one step toward less delay, and more than WINDOW/2 early samples give one step toward more delay. Any other outcome holds the code, including a tie and windows where both inputs are high.
- R5: A step toward less delay is ignored when the code is all ones, and a step toward more delay is ignored when it is all zeros. Each ignored step sets `limit_o`, which stays set until reset.
- R6: While `man_mode_i`=1 the automatic loop makes no change, and the samples of a partial window are thrown away.
- R7: In manual mode, `man_wr_i`=1 loads `man_code_i` on the next edge when that value is a valid thermometer code. An invalid value is rejected and leaves the code unchanged.
- R8: In manual mode without a write, `man_more_i` alone takes one step toward more delay and `man_less_i` alone takes one step toward less delay, and both limits of R5 still apply. Both inputs together hold the code, and a write takes priority over any step.
- R9: `lock_o` goes high at the automatic step that completes the fourth direction reversal in a row. It goes low at an automatic step that repeats the direction before it. Manual mode clears `lock_o` and the direction history.
- R10: `clk_gate_o` equals `clk_en_i` delayed by one cycle, and `clk_en_i` has no effect on the code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| early_i | input | 1 | Phase comparator: regional clock arrives early |
| late_i | input | 1 | Phase comparator: regional clock arrives late |
| clk_en_i | input | 1 | Regional clock enable |
| man_mode_i | input | 1 | Manual control, stops the automatic loop |
| man_wr_i | input | 1 | Manual load of `man_code_i` |
| man_code_i | input | STEPS | Code for a manual load |
| man_more_i | input | 1 | Manual step toward more delay |
| man_less_i | input | 1 | Manual step toward less delay |
| code_o | output | STEPS | Thermometer tap-select code for the delay line |
| lock_o | output | 1 | Loop is dithering around alignment |
| limit_o | output | 1 | Sticky flag: a step was blocked at a range end |
| clk_gate_o | output | 1 | Registered enable for the regional clock gate |

## Verification
The bench looks hardest at the edges of the vote: a split of 8 against 8, 9 against 7, and windows with both comparator outputs high. A design that used a non-strict majority, or counted both-high samples, would step on windows where it should hold. Saturation is driven from a code loaded by hand at each end of the range. A design that wraps or overshoots would leave the thermometer form or fail to set the sticky flag. Lock is exercised with five alternating steps followed by a repeated step. A design that counted steps the wrong way, or let held windows reset the history, would raise or drop the flag one window off. Manual-mode tests cover rejected writes, simultaneous step requests, and partial windows left over at the switch back to automatic mode. Each of these shows up as a wrong code or a misplaced step.

// File: rtl/dll_deskew_pkg.sv
package dll_deskew_pkg;
   typedef enum logic [1:0] {
      DIR_NONE = 2'd0,
      DIR_LESS = 2'd1,
      DIR_MORE = 2'd2
   } dll_dir_e;
endpackage

// File: rtl/dll_window_voter.sv
module dll_window_voter
   import dll_deskew_pkg::*;
#(
   parameter int WINDOW = 16
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     freeze_i,
   input  logic     early_i,
   input  logic     late_i,
   output dll_dir_e dir_o
);
   localparam int CW     = (WINDOW > 2) ? $clog2(WINDOW) : 1;
   localparam int VW     = $clog2(WINDOW + 1);
   localparam int THRESH = WINDOW / 2;

   logic [CW-1:0] cnt_q;
   logic [VW-1:0] early_q, late_q, early_tot, late_tot;
   logic          e_smp, l_smp, last_cyc;

   assign e_smp     = early_i & ~late_i;
   assign l_smp     = late_i & ~early_i;
   assign early_tot = early_q + VW'(e_smp);
   assign late_tot  = late_q + VW'(l_smp);
   assign last_cyc  = (cnt_q == CW'(WINDOW - 1));

   always_comb begin
      dir_o = DIR_NONE;
      if (last_cyc && !freeze_i) begin
         if (late_tot > VW'(THRESH))       dir_o = DIR_LESS;
         else if (early_tot > VW'(THRESH)) dir_o = DIR_MORE;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cnt_q   <= '0;
         early_q <= '0;
         late_q  <= '0;
      end else if (freeze_i || last_cyc) begin
         cnt_q   <= '0;
         early_q <= '0;
         late_q  <= '0;
      end else begin
         cnt_q   <= cnt_q + CW'(1);
         early_q <= early_tot;
         late_q  <= late_tot;
      end
   end
endmodule

// File: rtl/dll_therm_reg.sv
module dll_therm_reg
   import dll_deskew_pkg::*;
#(
   parameter int STEPS      = 20,
   parameter int RESET_ONES = 10
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  dll_dir_e         auto_dir_i,
   input  logic             man_mode_i,
   input  logic             man_wr_i,
   input  logic [STEPS-1:0] man_code_i,
   input  logic             man_more_i,
   input  logic             man_less_i,
   output logic [STEPS-1:0] code_o,
   output logic             limit_o
);
   localparam logic [STEPS-1:0] RST_CODE = {STEPS{1'b1}} >> (STEPS - RESET_ONES);

   logic [STEPS-1:0] code_q;
   logic [STEPS-2:0] pair_ok;
   logic             wr_valid, want_less, want_more;

   // a bit may be 1 only if the bit below it is 1
   for (genvar i = 0; i < STEPS - 1; i++) begin : g_pair
      assign pair_ok[i] = man_code_i[i] | ~man_code_i[i+1];
   end
   assign wr_valid = &pair_ok;

   always_comb begin
      want_less = 1'b0;
      want_more = 1'b0;
      if (man_mode_i) begin
         if (!man_wr_i) begin
            want_less = man_less_i & ~man_more_i;
            want_more = man_more_i & ~man_less_i;
         end
      end else begin
         want_less = (auto_dir_i == DIR_LESS);
         want_more = (auto_dir_i == DIR_MORE);
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         code_q  <= RST_CODE;
         limit_o <= 1'b0;
      end else if (man_mode_i && man_wr_i) begin
         if (wr_valid) code_q <= man_code_i;
      end else if (want_less) begin
         if (code_q[STEPS-1]) limit_o <= 1'b1;
         else                 code_q  <= {code_q[STEPS-2:0], 1'b1};
      end else if (want_more) begin
         if (!code_q[0]) limit_o <= 1'b1;
         else            code_q  <= {1'b0, code_q[STEPS-1:1]};
      end
   end

   assign code_o = code_q;
endmodule

// File: rtl/dll_lock_det.sv
module dll_lock_det
   import dll_deskew_pkg::*;
#(
   parameter int ALTS = 4
) (
   input  logic     clk_i,
   input  logic     rst_ni,
   input  logic     clear_i,
   input  dll_dir_e dir_i,
   output logic     lock_o
);
   localparam int AW = $clog2(ALTS + 1);

   dll_dir_e      last_q;
   logic [AW-1:0] alt_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         last_q <= DIR_NONE;
         alt_q  <= '0;
         lock_o <= 1'b0;
      end else if (clear_i) begin
         last_q <= DIR_NONE;
         alt_q  <= '0;
         lock_o <= 1'b0;
      end else if (dir_i != DIR_NONE) begin
         last_q <= dir_i;
         if (last_q != DIR_NONE && dir_i != last_q) begin
            if (alt_q != AW'(ALTS)) alt_q <= alt_q + AW'(1);
            if (alt_q >= AW'(ALTS - 1)) lock_o <= 1'b1;
         end else if (dir_i == last_q) begin
            alt_q  <= '0;
            lock_o <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/dll_deskew_ctrl.sv
module dll_deskew_ctrl
   import dll_deskew_pkg::*;
#(
   parameter int STEPS      = 20,
   parameter int WINDOW     = 16,
   parameter int LOCK_ALTS  = 4,
   parameter int RESET_ONES = STEPS / 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             early_i,
   input  logic             late_i,
   input  logic             clk_en_i,
   input  logic             man_mode_i,
   input  logic             man_wr_i,
   input  logic [STEPS-1:0] man_code_i,
   input  logic             man_more_i,
   input  logic             man_less_i,
   output logic [STEPS-1:0] code_o,
   output logic             lock_o,
   output logic             limit_o,
   output logic             clk_gate_o
);
   if (STEPS < 2) begin : g_bad_steps
      $error("STEPS must be at least 2");
   end
   if (WINDOW < 2) begin : g_bad_window
      $error("WINDOW must be at least 2");
   end
   if (LOCK_ALTS < 1) begin : g_bad_alts
      $error("LOCK_ALTS must be at least 1");
   end
   if (RESET_ONES < 0 || RESET_ONES > STEPS) begin : g_bad_reset
      $error("RESET_ONES out of range");
   end

   dll_dir_e auto_dir;

   dll_window_voter #(.WINDOW(WINDOW)) u_voter (
      .clk_i    (clk_i),
      .rst_ni   (rst_ni),
      .freeze_i (man_mode_i),
      .early_i  (early_i),
      .late_i   (late_i),
      .dir_o    (auto_dir)
   );

   dll_therm_reg #(.STEPS(STEPS), .RESET_ONES(RESET_ONES)) u_therm (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .auto_dir_i (auto_dir),
      .man_mode_i (man_mode_i),
      .man_wr_i   (man_wr_i),
      .man_code_i (man_code_i),
      .man_more_i (man_more_i),
      .man_less_i (man_less_i),
      .code_o     (code_o),
      .limit_o    (limit_o)
   );

   dll_lock_det #(.ALTS(LOCK_ALTS)) u_lock (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .clear_i (man_mode_i),
      .dir_i   (auto_dir),
      .lock_o  (lock_o)
   );

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) clk_gate_o <= 1'b0;
      else         clk_gate_o <= clk_en_i;
   end
endmodule

// File: rtl/dll_deskew_ctrl_chk.sv
module dll_deskew_ctrl_chk #(
   parameter int STEPS  = 20,
   parameter int WINDOW = 16
) (
   input logic             clk_i,
   input logic             rst_ni,
   input logic             clk_en_i,
   input logic             man_mode_i,
   input logic             man_wr_i,
   input logic             man_more_i,
   input logic             man_less_i,
   input logic [STEPS-1:0] code_o,
   input logic             lock_o,
   input logic             limit_o,
   input logic             clk_gate_o
);
   localparam int CW = (WINDOW > 2) ? $clog2(WINDOW) : 1;
   logic [CW-1:0] wcnt;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                wcnt <= '0;
      else if (man_mode_i || wcnt == CW'(WINDOW-1)) wcnt <= '0;
      else                                        wcnt <= wcnt + CW'(1);
   end

   // R2
   therm_form_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (code_o & (code_o + STEPS'(1))) == '0);

   // R2
   single_step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !man_wr_i |=> $countones(code_o ^ $past(code_o)) <= 1);

   // R3
   window_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!man_mode_i && wcnt != CW'(WINDOW-1)) |=> $stable(code_o));

   // R5
   limit_sticky_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      limit_o |=> limit_o);

   // R6
   manual_freeze_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (man_mode_i && !man_wr_i && !man_more_i && !man_less_i) |=> $stable(code_o));

   // R9
   manual_unlock_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      man_mode_i |=> !lock_o);

   // R10
   gate_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> clk_gate_o == $past(clk_en_i));
endmodule

bind dll_deskew_ctrl dll_deskew_ctrl_chk #(.STEPS(STEPS), .WINDOW(WINDOW)) u_chk (
   .clk_i      (clk_i),
   .rst_ni     (rst_ni),
   .clk_en_i   (clk_en_i),
   .man_mode_i (man_mode_i),
   .man_wr_i   (man_wr_i),
   .man_more_i (man_more_i),
   .man_less_i (man_less_i),
   .code_o     (code_o),
   .lock_o     (lock_o),
   .limit_o    (limit_o),
   .clk_gate_o (clk_gate_o)
);

// File: tb/dll_deskew_ctrl_bench.sv
`timescale 1ns/1ps
module dll_deskew_ctrl_bench;
   localparam int STEPS  = 20;
   localparam int WINDOW = 16;
   localparam int ALTS   = 4;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             early = 1'b0, late = 1'b0, en = 1'b0;
   logic             mm = 1'b0, wr = 1'b0, more = 1'b0, less = 1'b0;
   logic [STEPS-1:0] wcode = '0;
   logic [STEPS-1:0] code;
   logic             lock, limit, gate;

   int checks = 0;
   int errors = 0;
   string cur_tag = "R1";

   // model state
   int m_ones = STEPS / 2, m_cnt = 0, m_e = 0, m_l = 0, m_alt = 0, m_last = 0;
   bit m_lock = 0, m_limit = 0, m_gate = 0;

   always #2.5 clk = ~clk;

   dll_deskew_ctrl u_dll_deskew_ctrl (
      .clk_i(clk), .rst_ni(rst_n), .early_i(early), .late_i(late),
      .clk_en_i(en), .man_mode_i(mm), .man_wr_i(wr), .man_code_i(wcode),
      .man_more_i(more), .man_less_i(less),
      .code_o(code), .lock_o(lock), .limit_o(limit), .clk_gate_o(gate));

   function automatic logic [STEPS-1:0] therm(int n);
      logic [STEPS-1:0] r;
      for (int i = 0; i < STEPS; i++) r[i] = (i < n);
      return r;
   endfunction

   function automatic bit is_therm(logic [STEPS-1:0] v);
      bit seen0 = 0;
      for (int i = 0; i < STEPS; i++) begin
         if (!v[i]) seen0 = 1;
         else if (seen0) return 0;
      end
      return 1;
   endfunction

   task automatic check(bit ok, string tag, string what, longint act, longint exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
      end
   endtask

   // 1: less delay, 2: more delay
   function automatic void m_step(int dir);
      if (dir == 1) begin
         if (m_ones == STEPS) m_limit = 1; else m_ones++;
      end else if (dir == 2) begin
         if (m_ones == 0) m_limit = 1; else m_ones--;
      end
   endfunction

   function automatic void m_update();
      m_gate = en;
      if (mm) begin
         m_cnt = 0; m_e = 0; m_l = 0; m_lock = 0; m_alt = 0; m_last = 0;
         if (wr) begin
            if (is_therm(wcode)) m_ones = $countones(wcode);
         end else if (more && !less) m_step(2);
         else if (less && !more) m_step(1);
      end else begin
         int te, tl, dir;
         te = m_e + int'(early && !late);
         tl = m_l + int'(late && !early);
         if (m_cnt == WINDOW - 1) begin
            dir = (tl > WINDOW/2) ? 1 : (te > WINDOW/2) ? 2 : 0;
            m_cnt = 0; m_e = 0; m_l = 0;
            if (dir != 0) begin
               m_step(dir);
               if (m_last != 0 && dir != m_last) begin
                  if (m_alt < ALTS) m_alt++;
                  if (m_alt >= ALTS) m_lock = 1;
               end else if (dir == m_last) begin
                  m_alt = 0; m_lock = 0;
               end
               m_last = dir;
            end
         end else begin
            m_cnt++; m_e = te; m_l = tl;
         end
      end
   endfunction

   task automatic compare();
      check(code == therm(m_ones), cur_tag, "code_o", code, therm(m_ones));
      check(lock == m_lock, cur_tag, "lock_o", lock, m_lock);
      check(limit == m_limit, cur_tag, "limit_o", limit, m_limit);
      check(gate == m_gate, cur_tag, "clk_gate_o", gate, m_gate);
   endtask

   task automatic cyc();
      @(posedge clk);
      m_update();
      @(negedge clk);
      compare();
   endtask

   task automatic idle_in();
      early = 0; late = 0; mm = 0; wr = 0; more = 0; less = 0;
   endtask

   // one window: nl late-only, ne early-only, nb both, rest quiet
   task automatic window(int nl, int ne, int nb);
      for (int i = 0; i < WINDOW; i++) begin
         late  = (i < nl) || (i >= nl + ne && i < nl + ne + nb);
         early = (i >= nl && i < nl + ne + nb);
         cyc();
      end
      early = 0; late = 0;
   endtask

   task automatic man_cycle(bit w, logic [STEPS-1:0] c, bit mo, bit le);
      mm = 1; wr = w; wcode = c; more = mo; less = le;
      cyc();
      idle_in();
   endtask

   initial begin
      void'($urandom(32'h5EED_0D11));
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1;
      cur_tag = "R1";
      check(code == 20'h003FF, "R1", "reset code", code, 20'h003FF);
      check(!lock && !limit && !gate, "R1", "reset flags", {lock, limit, gate}, 0);

      // R4 majority votes
      cur_tag = "R4";
      window(16, 0, 0);
      check(code == 20'h007FF, "R4", "late window", code, 20'h007FF);
      window(0, 16, 0);
      check(code == 20'h003FF, "R4", "early window", code, 20'h003FF);
      window(8, 8, 0);
      check(code == 20'h003FF, "R4", "tie holds", code, 20'h003FF);
      window(0, 0, 16);
      check(code == 20'h003FF, "R4", "both holds", code, 20'h003FF);
      window(9, 0, 7);
      check(code == 20'h007FF, "R4", "9 of 16 late", code, 20'h007FF);
      window(0, 8, 0);
      check(code == 20'h007FF, "R4", "8 early holds", code, 20'h007FF);

      // R3 no change mid-window
      cur_tag = "R3";
      late = 1;
      for (int i = 0; i < WINDOW - 1; i++) cyc();
      check(code == 20'h007FF, "R3", "mid window", code, 20'h007FF);
      cyc();
      check(code == 20'h00FFF, "R3", "window end", code, 20'h00FFF);
      late = 0;

      // R6 partial window discarded
      cur_tag = "R6";
      late = 1;
      for (int i = 0; i < 10; i++) cyc();
      mm = 1; late = 1;
      for (int i = 0; i < 20; i++) cyc();
      check(code == 20'h00FFF, "R6", "manual freeze", code, 20'h00FFF);
      idle_in();
      window(8, 0, 0);
      check(code == 20'h00FFF, "R6", "stale votes dropped", code, 20'h00FFF);

      // R9 lock
      cur_tag = "R9";
      man_cycle(0, '0, 0, 0);
      window(16, 0, 0); window(0, 16, 0); window(16, 0, 0); window(0, 16, 0);
      check(!lock, "R9", "three reversals", lock, 0);
      window(16, 0, 0);
      check(lock, "R9", "fourth reversal", lock, 1);
      window(0, 0, 0);
      check(lock, "R9", "hold keeps lock", lock, 1);
      window(0, 16, 0);
      check(lock, "R9", "reversal keeps lock", lock, 1);
      window(0, 16, 0);
      check(!lock, "R9", "repeat clears", lock, 0);

      // R7 writes
      cur_tag = "R7";
      man_cycle(1, 20'h0001F, 0, 0);
      check(code == 20'h0001F, "R7", "valid write", code, 20'h0001F);
      man_cycle(1, 20'h00005, 0, 0);
      check(code == 20'h0001F, "R7", "invalid write rejected", code, 20'h0001F);

      // R8 steps
      cur_tag = "R8";
      man_cycle(0, '0, 1, 0);
      check(code == 20'h0000F, "R8", "manual more", code, 20'h0000F);
      man_cycle(0, '0, 0, 1);
      check(code == 20'h0001F, "R8", "manual less", code, 20'h0001F);
      man_cycle(0, '0, 1, 1);
      check(code == 20'h0001F, "R8", "both hold", code, 20'h0001F);
      man_cycle(1, 20'h000FF, 1, 0);
      check(code == 20'h000FF, "R8", "write wins", code, 20'h000FF);

      // R5 saturation
      cur_tag = "R5";
      man_cycle(1, 20'hFFFFF, 0, 0);
      check(!limit, "R5", "no limit yet", limit, 0);
      window(16, 0, 0);
      check(code == 20'hFFFFF && limit, "R5", "top saturate", {limit, code}, {1'b1, 20'hFFFFF});
      man_cycle(1, 20'h00000, 0, 0);
      man_cycle(0, '0, 1, 0);
      check(code == 20'h00000 && limit, "R5", "bottom saturate", {limit, code}, {1'b1, 20'h00000});

      // R10 gate
      cur_tag = "R10";
      en = 1; cyc();
      check(gate && code == 20'h00000, "R10", "gate on", {gate, code}, {1'b1, 20'h0});
      en = 0; cyc();
      check(!gate, "R10", "gate off", gate, 0);

      // R2 random mix
      cur_tag = "R2";
      for (int w = 0; w < 300; w++) begin
         int bias = $urandom % 4;
         if (w % 13 == 5) begin
            for (int k = 0; k < 3; k++) begin
               logic [STEPS-1:0] c;
               c = ($urandom % 3 == 0) ? STEPS'($urandom) : therm($urandom % (STEPS + 1));
               man_cycle($urandom % 2, c, $urandom % 2, $urandom % 2);
            end
         end
         for (int i = 0; i < WINDOW; i++) begin
            int r = $urandom % 10;
            en = $urandom % 2;
            case (bias)
               0: begin late = (r < 7); early = (r >= 8); end
               1: begin early = (r < 7); late = (r >= 8); end
               2: begin late = r[0]; early = r[1]; end
               default: begin late = (r < 5); early = (r < 8); end
            endcase
            cyc();
         end
      end
      idle_in();
      cyc();

      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end

   initial begin
      #(200000 * 5);
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule